// File: doc/BRIEF.md
# Lock-Region Status Register

This block keeps the region-lock state of a small serial nonvolatile memory. A 3-bit lock code lives in a status register. The block turns that code into a fixed address window in which array writes are refused. The memory's write sequencer presents each target address and gets back a single "write allowed" flag. Reads are never affected. The same register supplies the byte returned by the read-status command. While any internal nonvolatile write is running, that byte reads as all ones.

The serial shifter is outside the block. It hands over whole received bytes with a strobe, shows the live chip-select level, and raises a flag while a byte is only partly shifted in. The block tracks each chip-select frame itself:

- A one-byte enable frame sets the write-enable latch.
- A one-byte disable frame clears the write-enable latch.
- A lock frame (opcode followed by lock bytes) stages a new code.

A staged code starts a self-timed status write only if the latch is set and chip select rises on a byte boundary. The new code takes effect, and the latch clears, when that write finishes. A cold reset models first power-up and clears the code. The ordinary reset leaves the code as it was, which models nonvolatile retention.

Top module: `lockreg_guard`

## Requirements
- R1: Cold reset clears the lock code to 0 and the write-enable latch, so the status byte reads 00h and every address is writable. The warm reset clears the latch and aborts a running status write, but keeps the lock code.
- R2: With the 9-bit default address, codes 1, 2, 3 and 4 each block writes to one quarter: 000h–07Fh, 080h–0FFh, 100h–17Fh and 180h–1FFh respectively. Code 0 blocks nothing. `wr_ok` is 0 exactly for blocked addresses.
- R3: Code 5 blocks 000h–0FFh. Code 6 blocks the first 16-byte page, 000h–00Fh. Code 7 blocks the last page, 1F0h–1FFh.
- R4: When no write is in progress, `stat_byte` has bits 7:3 at zero and bits 2:0 equal to the active lock code.
- R5: A frame holding only the byte 06h, ended by chip select rising, sets `wel`. A frame holding only 04h clears it. Either opcode followed by further bytes in the same frame has no effect.
- R6: A frame of opcode 01h followed by at least one lock byte starts a status write when it closes, provided `wel` is 1. Only bits 2:0 of the lock byte are kept; bits 7:3 are dropped. With `wel` at 0 the frame changes nothing.
- R7: When a lock frame carries several lock bytes, the last one received is the one committed.
- R8: If chip select rises while `bit_pend` is 1, the frame is cancelled: no latch change and no commit.
- R9: A committed lock write keeps `stat_byte` at FFh for WR_CYCLES clocks after the closing edge. At the last of those edges the new code becomes active and `wel` clears.
- R10: While `array_busy` is 1 or a status write runs, `stat_byte` reads FFh and closing frames of every kind are ignored.
- R11: After any reset, bytes are ignored until chip select has been seen high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Warm synchronous reset, active high; lock code kept |
| cold_rst | input | 1 | Power-up synchronous reset, active high; clears lock code too |
| cs_n | input | 1 | Chip select level, low while a frame is open |
| byte_stb | input | 1 | One-cycle strobe: a full byte has arrived |
| byte_in | input | 8 | Received byte, valid with byte_stb |
| bit_pend | input | 1 | A byte is partly shifted in |
| array_busy | input | 1 | An array write is in progress |
| wr_addr | input | ADDR_W | Address of a proposed array write |
| wel | output | 1 | Write-enable latch |
| stat_byte | output | 8 | Byte returned by read status |
| wr_ok | output | 1 | 1 when wr_addr lies outside the locked window |

## Verification
Each of the eight codes is made active in turn, and then every address is swept. This separates the quarter windows from the half and page windows and exposes off-by-one edges at 07Fh/080h, 00Fh/010h and 1EFh/1F0h.

The frames are varied so that each gate on a commit is tested on its own:
- a well-formed lock frame with the latch set;
- the same frame with the latch clear;
- a frame closed mid-byte;
- a frame with extra lock bytes;
- frames sent while the array is busy;
- a frame that began before reset.

A per-clock reference comparison also pins down the exact edge at which the busy window ends, the code switches and the latch drops.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_LOCK = 8'h01;
    localparam logic [7:0] STAT_BUSY = 8'hFF;

    typedef logic [2:0] lock_code_t;

    // how far into the current frame the byte stream has gone
    typedef enum logic [1:0] {
        PH_EMPTY = 2'd0,
        PH_OPC   = 2'd1,
        PH_DATA  = 2'd2
    } frame_phase_t;

    // actions decided when a frame closes
    typedef struct packed {
        logic wren;
        logic wrdi;
        logic commit;
    } frame_ev_t;

    typedef struct packed {
        logic        en;
        int unsigned lo;
        int unsigned hi;
    } lock_win_t;

    function automatic lock_win_t lock_window(input lock_code_t c,
                                              input int unsigned depth,
                                              input int unsigned page);
        lock_win_t   w;
        int unsigned q;
        q    = depth / 4;
        w.en = 1'b1;
        w.lo = 0;
        w.hi = 0;
        case (c)
            3'd1, 3'd2, 3'd3, 3'd4: begin
                w.lo = (int'(c) - 1) * q;
                w.hi = w.lo + q - 1;
            end
            3'd5: w.hi = depth / 2 - 1;
            3'd6: w.hi = page - 1;
            3'd7: begin
                w.lo = depth - page;
                w.hi = depth - 1;
            end
            default: w.en = 1'b0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/lockreg_frame.sv
module lockreg_frame
    import lockreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       byte_stb,
    input  logic [7:0] byte_in,
    input  logic       bit_pend,
    output frame_ev_t  ev,
    output lock_code_t pend_code
);

    logic         armed;
    logic         cs_q;
    frame_phase_t phase;
    logic [7:0]   opcode;
    logic         close_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            cs_q      <= 1'b1;
            phase     <= PH_EMPTY;
            opcode    <= 8'h00;
            pend_code <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                armed <= 1'b1;
                phase <= PH_EMPTY;
            end else if (byte_stb && armed) begin
                if (phase == PH_EMPTY) begin
                    opcode <= byte_in;
                    phase  <= PH_OPC;
                end else begin
                    if (opcode == OP_LOCK)
                        pend_code <= byte_in[2:0];
                    phase <= PH_DATA;
                end
            end
        end
    end

    // frame closes on a rising chip select that lands on a byte boundary
    assign close_ok  = !cs_q && cs_n && !bit_pend;
    assign ev.wren   = close_ok && (phase == PH_OPC)  && (opcode == OP_WREN);
    assign ev.wrdi   = close_ok && (phase == PH_OPC)  && (opcode == OP_WRDI);
    assign ev.commit = close_ok && (phase == PH_DATA) && (opcode == OP_LOCK);

    // R11
    armed_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(cs_n));

    // R8
    partial_close_chk: assert property (@(posedge clk) disable iff (rst)
        bit_pend |-> (ev == '0));

endmodule

// File: rtl/lockreg_nvstat.sv
module lockreg_nvstat
    import lockreg_pkg::*;
#(
    parameter int WR_CYCLES = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cold_rst,
    input  frame_ev_t  ev,
    input  lock_code_t pend_code,
    input  logic       array_busy,
    output logic       wel,
    output lock_code_t code,
    output logic       busy_int
);

    localparam int TMR_W = $clog2(WR_CYCLES + 1);

    logic [TMR_W-1:0] tmr;
    lock_code_t       staged;
    logic             busy_any;
    logic             finishing;

    assign busy_int  = (tmr != '0);
    assign busy_any  = busy_int || array_busy;
    assign finishing = (tmr == TMR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wel    <= 1'b0;
            tmr    <= '0;
            staged <= '0;
        end else if (busy_int) begin
            tmr <= tmr - TMR_W'(1);
            if (finishing)
                wel <= 1'b0;
        end else if (!array_busy) begin
            if (ev.commit && wel) begin
                staged <= pend_code;
                tmr    <= TMR_W'(WR_CYCLES);
            end else if (ev.wren) begin
                wel <= 1'b1;
            end else if (ev.wrdi) begin
                wel <= 1'b0;
            end
        end
    end

    // the lock code survives the warm reset and is only cleared at power-up
    always_ff @(posedge clk) begin
        if (cold_rst)
            code <= '0;
        else if (!rst && finishing)
            code <= staged;
    end

    // R9
    code_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (code != $past(code)) |-> $past(busy_int));

    // R6
    commit_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_int) |-> $past(wel));

    // R9
    wel_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_int) |-> !wel);

    // R10
    quiet_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $past(busy_any) |-> $stable(staged) || $past(busy_int));

endmodule

// File: rtl/lockreg_range.sv
module lockreg_range
    import lockreg_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16
) (
    input  lock_code_t        code,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_ok
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    lock_win_t   win;
    int unsigned a;
    logic        hit;

    always_comb begin
        win   = lock_window(code, DEPTH, PAGE_BYTES);
        a     = 32'(wr_addr);
        hit   = win.en && (a >= win.lo) && (a <= win.hi);
        wr_ok = !hit;
    end

    // R2
    always_comb begin
        if (code == 3'd0)
            free_code_chk: assert (wr_ok);
    end

endmodule

// File: rtl/lockreg_guard.sv
module lockreg_guard
    import lockreg_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cold_rst,
    input  logic              cs_n,
    input  logic              byte_stb,
    input  logic [7:0]        byte_in,
    input  logic              bit_pend,
    input  logic              array_busy,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wel,
    output logic [7:0]        stat_byte,
    output logic              wr_ok
);

    logic       rst_any;
    frame_ev_t  ev;
    lock_code_t pend_code;
    lock_code_t code;
    logic       busy_int;

    assign rst_any = rst || cold_rst;

    lockreg_frame u_frame (
        .clk       (clk),
        .rst       (rst_any),
        .cs_n      (cs_n),
        .byte_stb  (byte_stb),
        .byte_in   (byte_in),
        .bit_pend  (bit_pend),
        .ev        (ev),
        .pend_code (pend_code)
    );

    lockreg_nvstat #(.WR_CYCLES(WR_CYCLES)) u_nv (
        .clk        (clk),
        .rst        (rst_any),
        .cold_rst   (cold_rst),
        .ev         (ev),
        .pend_code  (pend_code),
        .array_busy (array_busy),
        .wel        (wel),
        .code       (code),
        .busy_int   (busy_int)
    );

    lockreg_range #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_range (
        .code    (code),
        .wr_addr (wr_addr),
        .wr_ok   (wr_ok)
    );

    assign stat_byte = (busy_int || array_busy) ? STAT_BUSY : {5'b00000, code};

    // R10
    stat_busy_chk: assert property (@(posedge clk) disable iff (rst_any)
        array_busy |-> (stat_byte == 8'hFF));

    // R4
    stat_pad_chk: assert property (@(posedge clk) disable iff (rst_any)
        (!array_busy && stat_byte != 8'hFF) |-> (stat_byte[7:3] == 5'd0));

    // R5
    wel_rise_chk: assert property (@(posedge clk) disable iff (rst_any)
        $rose(wel) |-> $past(cs_n));

endmodule

// File: tb/lockreg_guard_test.sv
`timescale 1ns/1ps
module lockreg_guard_test;

    localparam int WR = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b0;
    logic       cold_rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       bit_pend = 1'b0;
    logic       array_busy = 1'b0;
    logic [8:0] wr_addr = 9'd0;
    logic       wel;
    logic [7:0] stat_byte;
    logic       wr_ok;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    int m_code = 0, m_stage = 0, m_tmr = 0, m_wel = 0;
    int m_armed = 0, m_cnt = 0, m_op = 0, m_pend = 0, m_csq = 1;

    always #2.5 clk = ~clk;

    lockreg_guard uut (
        .clk(clk), .rst(rst), .cold_rst(cold_rst), .cs_n(cs_n),
        .byte_stb(byte_stb), .byte_in(byte_in), .bit_pend(bit_pend),
        .array_busy(array_busy), .wr_addr(wr_addr),
        .wel(wel), .stat_byte(stat_byte), .wr_ok(wr_ok)
    );

    function automatic bit ref_locked(int c, int a);
        case (c)
            1: return a < 128;
            2: return a >= 128 && a < 256;
            3: return a >= 256 && a < 384;
            4: return a >= 384;
            5: return a < 256;
            6: return a < 16;
            7: return a >= 496;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst || cold_rst) begin
            m_wel = 0; m_tmr = 0; m_armed = 0; m_cnt = 0; m_csq = 1;
            if (cold_rst) m_code = 0;
        end else begin
            int close;
            close = (m_csq == 0) && cs_n && !bit_pend;
            if (m_tmr != 0) begin
                m_tmr--;
                if (m_tmr == 0) begin m_code = m_stage; m_wel = 0; end
            end else if (!array_busy && close) begin
                if (m_cnt == 2 && m_op == 1 && m_wel == 1) begin
                    m_stage = m_pend; m_tmr = WR;
                end else if (m_cnt == 1 && m_op == 6) m_wel = 1;
                else if (m_cnt == 1 && m_op == 4) m_wel = 0;
            end
            if (cs_n) begin m_cnt = 0; m_armed = 1; end
            else if (byte_stb && m_armed == 1) begin
                if (m_cnt == 0) m_op = int'(byte_in);
                else if (m_op == 1) m_pend = int'(byte_in) % 8;
                if (m_cnt < 2) m_cnt++;
            end
            m_csq = cs_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison, 2 ns after inputs settle, before the next edge
    always @(negedge clk) begin
        #2;
        if (!rst && !cold_rst && !done) begin
            int es;
            es = (m_tmr != 0 || array_busy) ? 255 : m_code;
            chk(wel === m_wel[0], "R5 wel", int'(wel), m_wel);
            chk(stat_byte === es[7:0], "R4/R9 stat_byte", int'(stat_byte), es);
            chk(wr_ok === !ref_locked(m_code, int'(wr_addr)), "R2/R3 wr_ok",
                int'(wr_ok), int'(!ref_locked(m_code, int'(wr_addr))));
        end
    end

    task automatic frame(input logic [7:0] b0, b1, b2, input int n, input bit partial);
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_stb = 1'b1;
            byte_in  = (i == 0) ? b0 : (i == 1) ? b1 : b2;
            @(negedge clk) byte_stb = 1'b0;
        end
        @(negedge clk);
        bit_pend = partial;
        cs_n     = 1'b1;
        @(negedge clk) bit_pend = 1'b0;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (WR + 3) @(negedge clk);
    endtask

    task automatic sweep();
        for (int a = 0; a < 512; a++) @(negedge clk) wr_addr = 9'(a);
    endtask

    task automatic set_code(input logic [7:0] v);
        frame(8'h06, 8'h00, 8'h00, 1, 0);
        frame(8'h01, v, 8'h00, 2, 0);
        settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: frame already open when reset lifts
        cs_n = 1'b0;
        @(negedge clk) cold_rst = 1'b0;
        @(negedge clk) begin byte_stb = 1'b1; byte_in = 8'h06; end
        @(negedge clk) byte_stb = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(wel === 1'b0, "R11 stale frame", int'(wel), 0);
        // R1
        chk(stat_byte === 8'h00, "R1 reset status", int'(stat_byte), 0);
        // R5
        frame(8'h06, 8'h00, 8'h00, 1, 0);
        chk(wel === 1'b1, "R5 set", int'(wel), 1);
        frame(8'h04, 8'h00, 8'h00, 1, 0);
        chk(wel === 1'b0, "R5 clear", int'(wel), 0);
        frame(8'h06, 8'h55, 8'h00, 2, 0);
        chk(wel === 1'b0, "R5 extra byte", int'(wel), 0);
        // R6: latch clear
        frame(8'h01, 8'h03, 8'h00, 2, 0);
        settle();
        chk(stat_byte === 8'h00, "R6 no wel", int'(stat_byte), 0);
        // R6 masking + R9 busy window
        frame(8'h06, 8'h00, 8'h00, 1, 0);
        frame(8'h01, 8'hF9, 8'h00, 2, 0);
        chk(stat_byte === 8'hFF, "R9 busy", int'(stat_byte), 255);
        settle();
        chk(stat_byte === 8'h01, "R6 mask", int'(stat_byte), 1);
        chk(wel === 1'b0, "R9 wel cleared", int'(wel), 0);
        sweep();
        // R2/R3: all other codes
        for (int c = 2; c < 8; c++) begin
            set_code(8'(c));
            chk(stat_byte === 8'(c), "R3 code", int'(stat_byte), c);
            sweep();
        end
        set_code(8'h00);
        sweep();
        // R7
        frame(8'h06, 8'h00, 8'h00, 1, 0);
        frame(8'h01, 8'h02, 8'h05, 3, 0);
        settle();
        chk(stat_byte === 8'h05, "R7 last wins", int'(stat_byte), 5);
        // R8
        frame(8'h06, 8'h00, 8'h00, 1, 0);
        frame(8'h01, 8'h06, 8'h00, 2, 1);
        settle();
        chk(stat_byte === 8'h05, "R8 partial", int'(stat_byte), 5);
        chk(wel === 1'b1, "R8 wel kept", int'(wel), 1);
        // R10
        array_busy = 1'b1;
        frame(8'h01, 8'h07, 8'h00, 2, 0);
        frame(8'h04, 8'h00, 8'h00, 1, 0);
        chk(stat_byte === 8'hFF, "R10 busy status", int'(stat_byte), 255);
        @(negedge clk) array_busy = 1'b0;
        settle();
        chk(stat_byte === 8'h05, "R10 ignored lock", int'(stat_byte), 5);
        chk(wel === 1'b1, "R10 ignored wrdi", int'(wel), 1);
        // R1: warm reset keeps code
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(stat_byte === 8'h05, "R1 warm keep", int'(stat_byte), 5);
        chk(wel === 1'b0, "R1 warm wel", int'(wel), 0);
        // R1: cold reset clears
        @(negedge clk) cold_rst = 1'b1;
        repeat (2) @(negedge clk);
        cold_rst = 1'b0;
        @(negedge clk);
        chk(stat_byte === 8'h00, "R1 cold clear", int'(stat_byte), 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule